// File: doc/BRIEF.md
# Interrupt cause register bank

This block collects interrupt events from three sources (TX, RX and MISC) into three groups of cause bits. Every group can be forced by software, masked and unmasked bit by bit, and read back as raw, masked and mask values. Each cause bit has a clear-mode bit of its own. When that bit is 1, the cause bit clears when the cause register is read. When it is 0, the cause bit clears only when software writes a 1 to it.

Above the three groups sits a summary register with one bit per group. A bit in it latches whenever its group has any unmasked cause pending, and the summary register clears on read. A software mask gates the summary bits. The single interrupt line is high while any summary bit is set and not blocked by that mask. Software reads the summary register to learn which group to service, masks that group while it works, then clears the causes and unmasks the group again.

Accesses use a simple port. A word address selects a group in `addr[4:3]` (0 TX, 1 RX, 2 MISC, 3 summary) and a register in `addr[2:0]`. Reads take one cycle: `rdata` is loaded at the clock edge that samples `rd_en`, and holds its value between reads.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, and in every group, the cause bits are 0, the mask bits are 1 and the clear-mode bits are 0. The summary-mask register reads 0xFFFFFFFF, the summary register reads 0 and `irq` is low.
- R2: A 1 on a bit of `hw_evt` sets the matching cause bit at that clock edge. Group g uses `hw_evt[32g+31:32g]`, and the bit can be read at group offset 0.
- R3: Writing ones to the cause-set register (offset 1) raises those cause bits exactly as hardware events would.
- R4: Reading the cause register clears the bits whose clear-mode bit (offset 4) is 1, and leaves the bits whose clear-mode bit is 0 unchanged. The read returns the value held before the clear.
- R5: Writing to the cause register clears the bits that are written as 1 and whose clear-mode bit is 0. Written ones on clear-on-read bits, and written zeros, have no effect.
- R6: When a set (hardware event or cause-set write) and a clear (read or write) hit the same cause bit in one cycle, the bit ends up set.
- R7: Writing ones to mask-set (offset 2) sets those mask bits, and writing ones to mask-clear (offset 3) clears them. The mask-value view (offset 6) returns the mask.
- R8: The masked view (offset 5) returns cause AND NOT mask, and reading it clears nothing.
- R9: Summary bit g (bit 0 TX, bit 1 RX, bit 2 MISC) is set at the edge after its group has any unmasked pending cause. A group whose mask is all ones never sets its summary bit.
- R10: Reading the summary register (group 3, offset 0) returns the summary bits that are not blocked, and clears those bits. A bit whose group is still pending is set again at once.
- R11: The summary mask (group 3, offset 1) blocks summary bit g when its bit g is 1. It reads back with the upper bits as ones. Writing all ones blocks everything, and writing 0xFFFFFFF8 enables all three groups.
- R12: `irq` is high exactly while some summary bit is set and not blocked.
- R13: With the MISC clear-mode set to 0xF7FFFFFF, bit 27 clears only by a write of 1, while the other bits clear on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address: group in [4:3], register in [2:0] |
| wdata | input | 32 | Write data |
| hw_evt | input | 96 | Hardware event bits, 32 per group: TX, RX, MISC |
| rdata | output | 32 | Read data, loaded at the edge that samples rd_en |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: 32-bit groups and three groups. With these values bit 27 of MISC and the top cause bits exist, so the mixed clear-mode value and all-ones mask writes can be exercised exactly as specified. Directed sequences cover a clear and a set colliding on the same bit, a summary bit that stays latched after its cause is gone, and a group masked while its cause is still pending. A long run of random accesses and sparse events then covers interleavings of reads, writes and events across all groups, compared against the behavioural model on every clock.

// File: rtl/icb_pkg.sv
package icb_pkg;
  // register offsets inside a cause group
  localparam logic [2:0] OFF_CAUSE = 3'd0;
  localparam logic [2:0] OFF_SET   = 3'd1;
  localparam logic [2:0] OFF_MSET  = 3'd2;
  localparam logic [2:0] OFF_MCLR  = 3'd3;
  localparam logic [2:0] OFF_MODE  = 3'd4;
  localparam logic [2:0] OFF_MVIEW = 3'd5;
  localparam logic [2:0] OFF_MVAL  = 3'd6;
  // register offsets inside the summary group
  localparam logic [2:0] OFF_SUM   = 3'd0;
  localparam logic [2:0] OFF_SMASK = 3'd1;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [2:0] off;
  } acc_t;
endpackage

// File: rtl/icb_rst_sync.sv
module icb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/icb_group.sv
module icb_group
  import icb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  acc_t         acc,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_evt,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic         any_o
);
  logic [W-1:0] cause_q, cause_d;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] mode_q, mode_d;
  logic [W-1:0] set_v, clr_v;
  logic         cause_en, mask_en, mode_en;
  logic         wr_hit, rd_hit;

  always_comb begin
    wr_hit = sel & acc.wr;
    rd_hit = sel & acc.rd;

    set_v = hw_evt;
    if (wr_hit && acc.off == OFF_SET) set_v = set_v | wdata;

    clr_v = '0;
    if (rd_hit && acc.off == OFF_CAUSE) clr_v = clr_v | mode_q;
    if (wr_hit && acc.off == OFF_CAUSE) clr_v = clr_v | (wdata & ~mode_q);

    // set wins over clear
    cause_d  = (cause_q & ~clr_v) | set_v;
    cause_en = (|set_v) | (|clr_v);

    mask_en = wr_hit && (acc.off == OFF_MSET || acc.off == OFF_MCLR);
    mask_d  = (acc.off == OFF_MSET) ? (mask_q | wdata) : (mask_q & ~wdata);

    mode_en = wr_hit && (acc.off == OFF_MODE);
    mode_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  always_comb begin
    case (acc.off)
      OFF_CAUSE: rd_val = cause_q;
      OFF_MODE:  rd_val = mode_q;
      OFF_MVIEW: rd_val = cause_q & ~mask_q;
      OFF_MVAL:  rd_val = mask_q;
      default:   rd_val = '0;
    endcase
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign any_o   = |(cause_q & ~mask_q);
endmodule

// File: rtl/icb_summary.sv
module icb_summary #(
  parameter int N_GRP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_GRP-1:0] grp_any,
  input  logic             smask_wr,
  input  logic [N_GRP-1:0] smask_wdata,
  input  logic             sum_rd,
  output logic [N_GRP-1:0] sum_view,
  output logic [N_GRP-1:0] sum_q,
  output logic [N_GRP-1:0] smask_q,
  output logic             irq
);
  logic [N_GRP-1:0] sum_d, sum_clr;
  logic             sum_en;

  always_comb begin
    sum_view = sum_q & ~smask_q;
    sum_clr  = sum_rd ? sum_view : '0;
    // pending group re-latches over the read clear
    sum_d    = (sum_q & ~sum_clr) | grp_any;
    sum_en   = sum_rd | (|grp_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      if (sum_en)   sum_q   <= sum_d;
      if (smask_wr) smask_q <= smask_wdata;
    end
  end

  assign irq = |sum_view;
endmodule

// File: rtl/icb_read_mux.sv
module icb_read_mux
  import icb_pkg::*;
#(
  parameter int N_GRP  = 3,
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_GRP*W-1:0] grp_vals,
  input  logic [N_GRP-1:0]   sum_view,
  input  logic [N_GRP-1:0]   smask_q,
  output logic [W-1:0]       rdata
);
  localparam int GAW = ADDR_W - 3;

  logic [GAW-1:0] grp_idx;
  logic [2:0]     off;
  logic [W-1:0]   rd_d;

  always_comb begin
    grp_idx = addr[ADDR_W-1:3];
    off     = addr[2:0];
    rd_d    = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (grp_idx == GAW'(g)) rd_d = grp_vals[g*W +: W];
    end
    if (grp_idx == GAW'(N_GRP)) begin
      if (off == OFF_SUM) begin
        rd_d[N_GRP-1:0] = sum_view;
      end else if (off == OFF_SMASK) begin
        rd_d            = '1;
        rd_d[N_GRP-1:0] = smask_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import icb_pkg::*;
#(
  parameter int N_GRP  = 3,
  parameter int W      = 32,
  parameter int ADDR_W = $clog2(N_GRP + 1) + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [W-1:0]       wdata,
  input  logic [N_GRP*W-1:0] hw_evt,
  output logic [W-1:0]       rdata,
  output logic               irq
);
  localparam int GAW = ADDR_W - 3;

  logic               rst_n_sync;
  acc_t               acc;
  logic [GAW-1:0]     grp_idx;
  logic               top_sel;
  logic [N_GRP*W-1:0] grp_vals;
  logic [N_GRP*W-1:0] cause_all;
  logic [N_GRP*W-1:0] mask_all;
  logic [N_GRP-1:0]   grp_any;
  logic [N_GRP-1:0]   sum_view;
  logic [N_GRP-1:0]   sum_all;
  logic [N_GRP-1:0]   smask_all;

  icb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    acc.wr  = wr_en;
    acc.rd  = rd_en;
    acc.off = addr[2:0];
    grp_idx = addr[ADDR_W-1:3];
    top_sel = (grp_idx == GAW'(N_GRP));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : gen_grp
    icb_group #(.W(W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .sel     (grp_idx == GAW'(g)),
      .acc     (acc),
      .wdata   (wdata),
      .hw_evt  (hw_evt[g*W +: W]),
      .rd_val  (grp_vals[g*W +: W]),
      .cause_o (cause_all[g*W +: W]),
      .mask_o  (mask_all[g*W +: W]),
      .any_o   (grp_any[g])
    );
  end

  icb_summary #(.N_GRP(N_GRP)) u_sum (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .grp_any     (grp_any),
    .smask_wr    (wr_en && top_sel && addr[2:0] == OFF_SMASK),
    .smask_wdata (wdata[N_GRP-1:0]),
    .sum_rd      (rd_en && top_sel && addr[2:0] == OFF_SUM),
    .sum_view    (sum_view),
    .sum_q       (sum_all),
    .smask_q     (smask_all),
    .irq         (irq)
  );

  icb_read_mux #(.N_GRP(N_GRP), .W(W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rd_en    (rd_en),
    .addr     (addr),
    .grp_vals (grp_vals),
    .sum_view (sum_view),
    .smask_q  (smask_all),
    .rdata    (rdata)
  );
endmodule

// File: rtl/icb_chk.sv
module icb_chk #(
  parameter int N_GRP  = 3,
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [W-1:0]       wdata,
  input logic [N_GRP*W-1:0] hw_evt,
  input logic [N_GRP*W-1:0] cause_all,
  input logic [N_GRP*W-1:0] mask_all,
  input logic [N_GRP-1:0]   sum_all,
  input logic [N_GRP-1:0]   smask_all,
  input logic               irq
);
  for (genvar g = 0; g < N_GRP; g++) begin : gen_g
    localparam logic [ADDR_W-1:0] MSET_A = ADDR_W'(g * 8 + 2);

    // R2
    evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (hw_evt[g*W +: W] != '0) |=>
      ((cause_all[g*W +: W] & $past(hw_evt[g*W +: W])) == $past(hw_evt[g*W +: W])));

    // R9
    sum_latch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      ((cause_all[g*W +: W] & ~mask_all[g*W +: W]) != '0) |=> sum_all[g]);

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_ok)
      (wr_en && addr == MSET_A) |=>
      ((mask_all[g*W +: W] & $past(wdata)) == $past(wdata)));
  end

  // R11
  smask_block_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (&smask_all) |-> !irq);

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq |-> ((sum_all & ~smask_all) != '0));
endmodule

bind irq_cause_bank icb_chk #(.N_GRP(N_GRP), .W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .hw_evt    (hw_evt),
  .cause_all (cause_all),
  .mask_all  (mask_all),
  .sum_all   (sum_all),
  .smask_all (smask_all),
  .irq       (irq)
);

// File: tb/sim_irq_cause_bank.sv
`timescale 1ns/1ps
module sim_irq_cause_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [95:0] hw_evt;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [31:0] mc [0:2];
  logic [31:0] mm [0:2];
  logic [31:0] md [0:2];
  logic [2:0]  mpq, msw;
  logic [31:0] mrd;

  always #2.5 clk = ~clk;

  irq_cause_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .hw_evt(hw_evt), .rdata(rdata), .irq(irq)
  );

  function automatic logic [4:0] ra(input int g, input int of);
    return 5'(g * 8 + of);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [4:0] a,
                      input logic [31:0] d, input logic [95:0] ev, input string tag);
    logic [31:0] nc [0:2];
    logic [31:0] nm [0:2];
    logic [31:0] nd [0:2];
    logic [2:0]  any, npq, nsw;
    logic [31:0] rv, setv, clrv;
    int gi, of;
    gi = int'(a[4:3]);
    of = int'(a[2:0]);
    wr_en = w; rd_en = r; addr = a; wdata = d; hw_evt = ev;
    for (int g = 0; g < 3; g++) any[g] = |(mc[g] & ~mm[g]);
    rv = 32'h0;
    if (gi < 3) begin
      case (of)
        0: rv = mc[gi];
        4: rv = md[gi];
        5: rv = mc[gi] & ~mm[gi];
        6: rv = mm[gi];
        default: rv = 32'h0;
      endcase
    end else if (of == 0) rv = {29'h0, mpq & ~msw};
    else if (of == 1) rv = {29'h1fffffff, msw};
    for (int g = 0; g < 3; g++) begin
      setv = ev[g*32 +: 32];
      clrv = 32'h0;
      if (w && gi == g && of == 1) setv = setv | d;
      if (r && gi == g && of == 0) clrv = clrv | md[g];
      if (w && gi == g && of == 0) clrv = clrv | (d & ~md[g]);
      nc[g] = (mc[g] & ~clrv) | setv;
      nm[g] = mm[g];
      if (w && gi == g && of == 2) nm[g] = mm[g] | d;
      if (w && gi == g && of == 3) nm[g] = mm[g] & ~d;
      nd[g] = (w && gi == g && of == 4) ? d : md[g];
    end
    npq = mpq;
    if (r && gi == 3 && of == 0) npq = mpq & ~(mpq & ~msw);
    npq = npq | any;
    nsw = (w && gi == 3 && of == 1) ? d[2:0] : msw;
    @(posedge clk);
    for (int g = 0; g < 3; g++) begin
      mc[g] = nc[g]; mm[g] = nm[g]; md[g] = nd[g];
    end
    mpq = npq; msw = nsw;
    if (r) mrd = rv;
    @(negedge clk);
    chk({tag, " model rdata"}, rdata, mrd);
    chk({tag, " model irq"}, {31'h0, irq}, {31'h0, |(mpq & ~msw)});
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; hw_evt = '0;
  endtask

  task automatic rd(input int g, input int of, input logic [31:0] exp, input string tag);
    step(1'b0, 1'b1, ra(g, of), 32'h0, 96'h0, tag);
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input int g, input int of, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, ra(g, of), d, 96'h0, tag);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; hw_evt = '0;
    for (int g = 0; g < 3; g++) begin
      mc[g] = '0; mm[g] = '1; md[g] = '0;
    end
    mpq = '0; msw = '1; mrd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int g = 0; g < 3; g++) begin
      rd(g, 0, 32'h0, "R1 cause");
      rd(g, 6, 32'hFFFFFFFF, "R1 mask");
      rd(g, 4, 32'h0, "R1 mode");
    end
    rd(3, 1, 32'hFFFFFFFF, "R1 smask");
    rd(3, 0, 32'h0, "R1 sum");

    // R2 hardware event, R4 mode0 bit survives read
    step(1'b0, 1'b0, 5'h0, 32'h0, 96'h8, "R2 evt");
    rd(0, 0, 32'h8, "R2 tx cause");
    rd(0, 0, 32'h8, "R4 w1c bit kept on read");
    // R5 write one clears
    wr(0, 0, 32'h0, "R5 write zero");
    rd(0, 0, 32'h8, "R5 zero no effect");
    wr(0, 0, 32'h8, "R5 w1c");
    rd(0, 0, 32'h0, "R5 cleared");

    // R3 cause-set, R4 clear-on-read
    wr(1, 1, 32'h5, "R3 set");
    rd(1, 0, 32'h5, "R3 rx cause");
    wr(1, 4, 32'h1, "R4 mode");
    wr(1, 0, 32'h1, "R5 w1 on cor bit");
    rd(1, 0, 32'h5, "R5 cor bit ignores write");
    rd(1, 0, 32'h4, "R4 cleared on read");

    // R6 set beats clear
    step(1'b0, 1'b1, ra(1, 0), 32'h0, 96'h1 << 32, "R6 read+evt");
    chk("R6 read value", rdata, 32'h4);
    rd(1, 0, 32'h5, "R6 bit0 kept");
    step(1'b1, 1'b0, ra(1, 0), 32'h4, 96'h4 << 32, "R6 w1c+evt");
    rd(1, 0, 32'h4, "R6 bit2 kept");

    // R7 masks, R8 masked view
    wr(1, 3, 32'h4, "R7 mclr");
    rd(1, 6, 32'hFFFFFFFB, "R7 mask value");
    rd(1, 5, 32'h4, "R8 view");
    rd(1, 5, 32'h4, "R8 view no clear");
    chk("R11 irq blocked", {31'h0, irq}, 32'h0);

    // R9 R10 R11 R12 summary
    wr(3, 1, 32'hFFFFFFF8, "R11 enable");
    rd(3, 1, 32'hFFFFFFF8, "R11 smask readback");
    chk("R12 irq high", {31'h0, irq}, 32'h1);
    rd(3, 0, 32'h2, "R9 rx summary");
    rd(3, 0, 32'h2, "R10 relatch");
    wr(1, 0, 32'h4, "R10 clear cause");
    rd(3, 0, 32'h2, "R10 latched");
    rd(3, 0, 32'h0, "R10 cleared");
    chk("R12 irq low", {31'h0, irq}, 32'h0);

    // R13 mixed clear-mode
    wr(2, 4, 32'hF7FFFFFF, "R13 mode");
    wr(2, 1, 32'h08000001, "R13 set");
    rd(2, 0, 32'h08000001, "R13 read1");
    rd(2, 0, 32'h08000000, "R13 bit27 kept");
    wr(2, 0, 32'h08000000, "R13 w1c");
    rd(2, 0, 32'h0, "R13 cleared");

    // R9 mask-all stops contribution
    wr(2, 3, 32'h20, "R9 unmask");
    wr(2, 1, 32'h20, "R9 set");
    step(1'b0, 1'b0, 5'h0, 32'h0, 96'h0, "R9 idle");
    chk("R9 irq misc", {31'h0, irq}, 32'h1);
    wr(2, 2, 32'hFFFFFFFF, "R9 mask all");
    rd(2, 6, 32'hFFFFFFFF, "R7 all masked");
    rd(2, 5, 32'h0, "R8 view masked");
    rd(3, 0, 32'h4, "R10 stale bit");
    rd(3, 0, 32'h0, "R9 no contribution");
    chk("R9 irq off", {31'h0, irq}, 32'h0);
    rd(2, 0, 32'h20, "R9 still pending");

    // R11 all-ones blocks pending summary
    wr(2, 3, 32'h20, "R11 unmask");
    wr(2, 1, 32'h20, "R11 set");
    wr(3, 1, 32'hFFFFFFFF, "R11 block");
    step(1'b0, 1'b0, 5'h0, 32'h0, 96'h0, "R11 idle");
    chk("R11 irq blocked", {31'h0, irq}, 32'h0);
    rd(3, 0, 32'h0, "R11 sum blocked");
    wr(3, 1, 32'hFFFFFFF8, "R11 reopen");
    chk("R12 irq reopen", {31'h0, irq}, 32'h1);

    // random interleavings against the model
    for (int i = 0; i < 3000; i++) begin
      logic [95:0] ev;
      for (int g = 0; g < 3; g++) ev[g*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      step(($urandom % 4) == 0, ($urandom % 3) == 0, 5'($urandom), $urandom, ev, "R12 random");
    end

    summary();
  end
endmodule